// File: doc/BRIEF.md
# Guest memory descriptor list walker

This block builds the page map of one guest memory region from a descriptor list that software has placed in memory. Software first writes a region identifier to an ID register and then writes a physical page number to a descriptor register. A nonzero page number starts a walk. The walker reads two-word descriptors (page number, then page count) from that page over a word-read memory port that allows one request at a time. Each descriptor it finds is one of three kinds, told apart by which of its two fields are zero. A terminator ends the list. A run adds a stretch of pages, and the walker passes it on, in list order, to a map-table write port. A chain sends the walk to slot 0 of another descriptor page. A zero written to the descriptor register instead deletes the region named by the ID register.

The walker never moves from one descriptor page to the next on its own. Leaving a page without a chain is a fault. Faults also include a malformed descriptor, a list longer than the descriptor limit, and an identifier at or above the supported count. On any fault the walk stops, `error` pulses, and the region is undefined. `SLOTS` (descriptors per page) must be a power of two and `MAX_IDS` at least 2.

Top module: `gw_walker`

## Requirements
- R1: After reset `busy`, `done`, `error`, `mem_req`, `map_valid` and `map_del` are all low.
- R2: Writing the ID register (`reg_wr_sel`=0) has no side effect: no memory read, no map or delete strobe, no `done` or `error`.
- R3: Descriptor at slot s of page P is read as word P·2·SLOTS+2s (page number) then that address +1 (count). A descriptor with both fields nonzero emits one `map_valid` strobe carrying the page, the count and the walk's ID. Runs appear in list order.
- R4: A descriptor with page 0 and count 0 ends the walk with a one-cycle `done` pulse and no further reads.
- R5: A descriptor with a nonzero page and count 0 continues the walk at slot 0 of that page. A chain in the last slot of a page is legal.
- R6: A run in the last slot of a page is a fault: it is not emitted, `error` pulses, and reading stops.
- R7: A descriptor with page 0 and a nonzero count is a fault that ends the walk with `error`.
- R8: At most MAX_DESC descriptors are read per walk. A list that needs more ends with `error` after exactly MAX_DESC descriptors. `cap_desc_limit` reads MAX_DESC.
- R9: A descriptor-register write while the held ID is not below MAX_IDS pulses `error` with no read and no delete. `cap_max_ids` reads MAX_IDS.
- R10: Writing 0 to the descriptor register pulses `map_del` with the held ID, together with `done`, and reads no memory.
- R11: `busy` is high from the cycle after a walk starts until it ends. Descriptor-register writes while busy are ignored.
- R12: `mem_req` is a one-cycle pulse, and no new request is issued until the response (`mem_rvalid`) to the previous one has arrived.
- R13: `done` and `error` are one-cycle pulses, never both high, and `busy` is low in the cycle either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 selects the ID register, 1 the descriptor register |
| reg_wr_data | input | 32 | Write data |
| cap_max_ids | output | 32 | Read-only count of supported region IDs |
| cap_desc_limit | output | 32 | Read-only cap on descriptors read per walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Command completed pulse |
| error | output | 1 | Command aborted pulse |
| mem_req | output | 1 | Word read request pulse |
| mem_addr | output | PPN_W+log2(SLOTS)+1 | Word address of the request |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| map_valid | output | 1 | Run strobe to the map table |
| map_id | output | log2(MAX_IDS) | Region ID of the run |
| map_page | output | 32 | First page of the run |
| map_count | output | 32 | Number of pages in the run |
| map_del | output | 1 | Delete-region strobe |
| map_del_id | output | log2(MAX_IDS) | Region ID to delete |

## Verification
The bench sweeps single-page lists of zero to three runs across every legal ID and three response latencies. This separates correct slot stepping and list ordering from latency-dependent capture errors. Chained lists, including a chain in the last slot, show that the page switch resets the slot. A full page of runs, a malformed descriptor and a self-chaining page exercise each fault path. Two lists sized exactly at and one past the descriptor limit pin down the off-by-one point of the cap. Deletes, out-of-range IDs, lone ID writes and descriptor writes issued mid-walk confirm that these paths touch neither memory nor the map port.

// File: rtl/gw_pkg.sv
package gw_pkg;

  typedef enum logic [1:0] {K_END, K_RUN, K_CHAIN, K_BAD} desc_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WAIT} walk_state_e;
  typedef enum logic [1:0] {F_IDLE, F_W0, F_W1} fetch_state_e;

  // Kind of a descriptor from the zero pattern of its two words.
  function automatic desc_kind_e classify(input logic [31:0] pg, input logic [31:0] n);
    if (pg == 32'd0) return (n == 32'd0) ? K_END : K_BAD;
    return (n == 32'd0) ? K_CHAIN : K_RUN;
  endfunction

endpackage

// File: rtl/gw_fetch.sv
module gw_fetch
  import gw_pkg::*;
#(
  parameter int ADDR_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic [31:0]       word0,
  output logic [31:0]       word1
);

  fetch_state_e fst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fst      <= F_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      word0    <= '0;
      word1    <= '0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      case (fst)
        F_IDLE: if (start) begin
          mem_req  <= 1'b1;
          mem_addr <= base;
          fst      <= F_W0;
        end
        F_W0: if (mem_rvalid) begin
          word0    <= mem_rdata;
          mem_req  <= 1'b1;
          mem_addr <= {mem_addr[ADDR_W-1:1], 1'b1};
          fst      <= F_W1;
        end
        F_W1: if (mem_rvalid) begin
          word1 <= mem_rdata;
          done  <= 1'b1;
          fst   <= F_IDLE;
        end
        default: fst <= F_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gw_ctrl.sv
module gw_ctrl
  import gw_pkg::*;
#(
  parameter int PPN_W    = 20,
  parameter int SLOTS    = 512,
  parameter int MAX_IDS  = 64,
  parameter int MAX_DESC = 4096,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int ID_W    = $clog2(MAX_IDS),
  localparam int CNT_W   = $clog2(MAX_DESC + 1),
  localparam int ADDR_W  = PPN_W + SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_data,
  input  logic [31:0]       cur_id,
  output logic              fetch_start,
  output logic [ADDR_W-1:0] fetch_base,
  input  logic              fetch_done,
  input  logic [31:0]       word0,
  input  logic [31:0]       word1,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              map_valid,
  output logic [ID_W-1:0]   map_id,
  output logic [31:0]       map_page,
  output logic [31:0]       map_count,
  output logic              del_valid,
  output logic [ID_W-1:0]   del_id,
  output logic              evt_run,
  output logic              evt_end,
  output logic              evt_fault
);

  walk_state_e       st;
  logic [31:0]       page_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  nread_q;
  logic [ID_W-1:0]   wid_q;
  desc_kind_e        kind;
  logic              id_ok, at_limit, last_slot, got;

  assign id_ok       = cur_id < 32'(MAX_IDS);
  assign kind        = classify(word0, word1);
  assign at_limit    = nread_q == CNT_W'(MAX_DESC);
  assign last_slot   = slot_q == SLOT_W'(SLOTS - 1);
  assign got         = (st == S_WAIT) && fetch_done;
  assign fetch_start = (st == S_CHECK) && !at_limit;
  assign fetch_base  = {page_q[PPN_W-1:0], slot_q, 1'b0};
  assign busy        = st != S_IDLE;
  assign map_id      = wid_q;

  assign evt_run   = got && kind == K_RUN && !last_slot;
  assign evt_end   = got && kind == K_END;
  assign evt_fault = (got && (kind == K_BAD || (kind == K_RUN && last_slot)))
                   || (st == S_CHECK && at_limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      page_q    <= '0;
      slot_q    <= '0;
      nread_q   <= '0;
      wid_q     <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      map_valid <= 1'b0;
      map_page  <= '0;
      map_count <= '0;
      del_valid <= 1'b0;
      del_id    <= '0;
    end else begin
      done      <= 1'b0;
      err       <= 1'b0;
      map_valid <= 1'b0;
      del_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_wr) begin
          if (!id_ok) begin
            err <= 1'b1;
          end else if (cmd_data == 32'd0) begin
            del_valid <= 1'b1;
            del_id    <= cur_id[ID_W-1:0];
            done      <= 1'b1;
          end else begin
            page_q  <= cmd_data;
            slot_q  <= '0;
            nread_q <= '0;
            wid_q   <= cur_id[ID_W-1:0];
            st      <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (at_limit) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: if (fetch_done) begin
          nread_q <= nread_q + 1'b1;
          case (kind)
            K_END: begin
              done <= 1'b1;
              st   <= S_IDLE;
            end
            K_RUN: begin
              if (last_slot) begin
                err <= 1'b1;
                st  <= S_IDLE;
              end else begin
                map_valid <= 1'b1;
                map_page  <= word0;
                map_count <= word1;
                slot_q    <= slot_q + 1'b1;
                st        <= S_CHECK;
              end
            end
            K_CHAIN: begin
              page_q <= word0;
              slot_q <= '0;
              st     <= S_CHECK;
            end
            default: begin
              err <= 1'b1;
              st  <= S_IDLE;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gw_walker.sv
module gw_walker #(
  parameter int PPN_W    = 20,
  parameter int SLOTS    = 512,
  parameter int MAX_IDS  = 64,
  parameter int MAX_DESC = 4096,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int ID_W    = $clog2(MAX_IDS),
  localparam int ADDR_W  = PPN_W + SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_wr_sel,
  input  logic [31:0]       reg_wr_data,
  output logic [31:0]       cap_max_ids,
  output logic [31:0]       cap_desc_limit,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              map_valid,
  output logic [ID_W-1:0]   map_id,
  output logic [31:0]       map_page,
  output logic [31:0]       map_count,
  output logic              map_del,
  output logic [ID_W-1:0]   map_del_id
);

  logic [31:0]       id_q;
  logic              cmd_wr;
  logic              fetch_start, fetch_done;
  logic [ADDR_W-1:0] fetch_base;
  logic [31:0]       word0, word1;
  logic              evt_run, evt_end, evt_fault;

  assign cap_max_ids    = 32'(MAX_IDS);
  assign cap_desc_limit = 32'(MAX_DESC);
  assign cmd_wr         = reg_wr_en && reg_wr_sel && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)                      id_q <= '0;
    else if (reg_wr_en && !reg_wr_sel) id_q <= reg_wr_data;
  end

  gw_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk, .rst_n,
    .start(fetch_start), .base(fetch_base),
    .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
    .done(fetch_done), .word0, .word1
  );

  gw_ctrl #(.PPN_W(PPN_W), .SLOTS(SLOTS), .MAX_IDS(MAX_IDS), .MAX_DESC(MAX_DESC)) u_ctrl (
    .clk, .rst_n,
    .cmd_wr, .cmd_data(reg_wr_data), .cur_id(id_q),
    .fetch_start, .fetch_base, .fetch_done, .word0, .word1,
    .busy, .done, .err(error),
    .map_valid, .map_id, .map_page, .map_count,
    .del_valid(map_del), .del_id(map_del_id),
    .evt_run, .evt_end, .evt_fault
  );

endmodule

// File: rtl/gw_walker_chk.sv
module gw_walker_chk #(
  parameter int MAX_DESC = 4096
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        error,
  input logic        mem_req,
  input logic        mem_rvalid,
  input logic        map_valid,
  input logic [31:0] map_page,
  input logic [31:0] map_count,
  input logic        map_del,
  input logic        fetch_start,
  input logic        evt_run,
  input logic        evt_end,
  input logic        evt_fault
);

  logic        outst;
  logic [31:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst  <= 1'b0;
      rd_cnt <= '0;
    end else begin
      if (mem_req) outst <= 1'b1;
      else if (mem_rvalid) outst <= 1'b0;
      if (!busy) rd_cnt <= '0;
      else if (mem_req) rd_cnt <= rd_cnt + 1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !busy && !mem_req && !map_valid);
  p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !outst);
  p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req);
  p_start_issues_r12: assert property (@(posedge clk) disable iff (!rst_n) fetch_start |=> mem_req);
  p_run_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n) evt_run |=> map_valid);
  p_run_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |-> (map_page != 32'd0 && map_count != 32'd0));
  p_end_done_r4: assert property (@(posedge clk) disable iff (!rst_n) evt_end |=> done);
  p_fault_err_r6: assert property (@(posedge clk) disable iff (!rst_n) evt_fault |=> error);
  p_read_cap_r8: assert property (@(posedge clk) disable iff (!rst_n) rd_cnt <= 32'(2 * MAX_DESC));
  p_del_done_r10: assert property (@(posedge clk) disable iff (!rst_n) map_del |-> done && !busy);
  p_map_in_walk_r11: assert property (@(posedge clk) disable iff (!rst_n) map_valid |-> busy);
  p_excl_r13: assert property (@(posedge clk) disable iff (!rst_n) !(done && error));
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_err_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n) error |=> !error);
  p_end_idle_r13: assert property (@(posedge clk) disable iff (!rst_n) (done || error) |-> !busy);

endmodule

bind gw_walker gw_walker_chk #(.MAX_DESC(MAX_DESC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid), .map_valid(map_valid),
  .map_page(map_page), .map_count(map_count), .map_del(map_del),
  .fetch_start(fetch_start), .evt_run(evt_run), .evt_end(evt_end),
  .evt_fault(evt_fault)
);

// File: tb/sim_gw_walker.sv
`timescale 1ns/1ps
module sim_gw_walker;

  localparam int PPN_W = 4, SLOTS = 4, MAX_IDS = 4, MAX_DESC = 10;
  localparam int PW = 2 * SLOTS;
  localparam int AW = PPN_W + 2 + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] cap_max_ids, cap_desc_limit;
  logic busy, done, error, mem_req, mem_rvalid, map_valid, map_del;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata, map_page, map_count;
  logic [1:0] map_id, map_del_id;

  always #5 clk = ~clk;

  gw_walker #(.PPN_W(PPN_W), .SLOTS(SLOTS), .MAX_IDS(MAX_IDS), .MAX_DESC(MAX_DESC)) u0 (
    .clk, .rst_n, .reg_wr_en, .reg_wr_sel, .reg_wr_data, .cap_max_ids, .cap_desc_limit,
    .busy, .done, .error, .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
    .map_valid, .map_id, .map_page, .map_count, .map_del, .map_del_id
  );

  // memory model with programmable latency
  logic [31:0] mem [0:(1<<AW)-1];
  int lat = 1;
  logic [AW-1:0] pa;
  int pc;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (!rst_n) pc <= 0;
    else if (mem_req) begin pa <= mem_addr; pc <= lat; end
    else if (pc != 0) begin
      pc <= pc - 1;
      if (pc == 1) begin mem_rvalid <= 1'b1; mem_rdata <= mem[pa]; end
    end
  end

  // monitor
  int run_tot = 0, rd_tot = 0, dn_tot = 0, er_tot = 0, del_tot = 0, last_del_id = 0;
  logic [31:0] rec_pg [0:1023];
  logic [31:0] rec_ct [0:1023];
  int rec_id [0:1023];
  always @(negedge clk) if (rst_n) begin
    if (map_valid) begin
      rec_pg[run_tot % 1024] = map_page; rec_ct[run_tot % 1024] = map_count;
      rec_id[run_tot % 1024] = int'(map_id); run_tot++;
    end
    if (mem_req) rd_tot++;
    if (done) dn_tot++;
    if (error) er_tot++;
    if (map_del) begin del_tot++; last_del_id = int'(map_del_id); end
  end

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s: act=%0d exp=%0d", req, act, exp); end
  endtask

  task automatic put(input int pg, input int sl, input int a, input int b);
    mem[pg*PW + 2*sl]     = 32'(a);
    mem[pg*PW + 2*sl + 1] = 32'(b);
  endtask

  int exp_pg [0:15];
  int exp_ct [0:15];
  int exp_n;

  task automatic wr(input bit sel, input int d);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = 32'(d);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  int b_run, b_rd, b_dn, b_er, b_del;

  task automatic walk(input int id, input int d, input bit extra);
    b_run = run_tot; b_rd = rd_tot; b_dn = dn_tot; b_er = er_tot; b_del = del_tot;
    wr(0, id); wr(1, d);
    if (extra) begin
      chk(busy === 1'b1, "R11 busy during walk", busy, 1);
      wr(1, 0); wr(1, 3);
    end
    for (int i = 0; i < 3000 && (dn_tot + er_tot) == (b_dn + b_er); i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // compare one walk's outcome against expectations
  task automatic verify(input string req, input int id, input int ex_done, input int ex_err, input int ex_rd);
    chk(dn_tot - b_dn == ex_done, {req, " done count"}, dn_tot - b_dn, ex_done);
    chk(er_tot - b_er == ex_err, {req, " error count"}, er_tot - b_er, ex_err);
    chk(rd_tot - b_rd == ex_rd, {req, " word reads"}, rd_tot - b_rd, ex_rd);
    chk(run_tot - b_run == exp_n, {req, " run count"}, run_tot - b_run, exp_n);
    for (int k = 0; k < exp_n && k < run_tot - b_run; k++) begin
      int j = (b_run + k) % 1024;
      if (rec_pg[j] != 32'(exp_pg[k]) || rec_ct[j] != 32'(exp_ct[k]) || rec_id[j] != id) begin
        chk(1'b0, {req, " run page"}, rec_pg[j], exp_pg[k]);
        chk(1'b0, {req, " run count field"}, rec_ct[j], exp_ct[k]);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 0 && done === 0 && error === 0, "R1 status after reset", {busy, done, error}, 0);
    chk(mem_req === 0 && map_valid === 0 && map_del === 0, "R1 strobes after reset",
        {mem_req, map_valid, map_del}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cap_max_ids == 32'(MAX_IDS), "R9 id capacity port", cap_max_ids, MAX_IDS);
    chk(cap_desc_limit == 32'(MAX_DESC), "R8 limit port", cap_desc_limit, MAX_DESC);

    // R2 lone ID write
    b_run = run_tot; b_rd = rd_tot; b_dn = dn_tot; b_er = er_tot; b_del = del_tot;
    wr(0, 3);
    repeat (20) @(negedge clk);
    chk(rd_tot == b_rd && run_tot == b_run && del_tot == b_del, "R2 id write no traffic",
        rd_tot - b_rd + run_tot - b_run, 0);
    chk(dn_tot == b_dn && er_tot == b_er, "R2 id write no status", dn_tot - b_dn + er_tot - b_er, 0);

    // R3 R4 sweep: n runs then terminator, all ids, three latencies
    for (int l = 1; l <= 3; l++)
      for (int id = 0; id < MAX_IDS; id++)
        for (int n = 0; n < SLOTS; n++) begin
          lat = l;
          for (int s = 0; s < SLOTS; s++) put(1, s, 32'h5A, 7);
          exp_n = n;
          for (int k = 0; k < n; k++) begin
            exp_pg[k] = 16*n + 3*k + id + 1; exp_ct[k] = k + 2 + l;
            put(1, k, exp_pg[k], exp_ct[k]);
          end
          put(1, n, 0, 0);
          walk(id, 1, 1'b0);
          verify("R3 R4 sweep", id, 1, 0, 2*(n+1));
        end
    lat = 1;

    // R5 chain mid page
    put(2, 0, 9, 1); put(2, 1, 3, 0); put(3, 0, 10, 4); put(3, 1, 0, 0);
    exp_n = 2; exp_pg[0] = 9; exp_ct[0] = 1; exp_pg[1] = 10; exp_ct[1] = 4;
    walk(1, 2, 1'b0);
    verify("R5 chain", 1, 1, 0, 8);

    // R5 chain in last slot
    put(4, 0, 20, 1); put(4, 1, 21, 2); put(4, 2, 22, 3); put(4, 3, 5, 0); put(5, 0, 0, 0);
    exp_n = 3;
    for (int k = 0; k < 3; k++) begin exp_pg[k] = 20 + k; exp_ct[k] = k + 1; end
    walk(2, 4, 1'b0);
    verify("R5 last-slot chain", 2, 1, 0, 10);

    // R6 run in last slot
    for (int s = 0; s < SLOTS; s++) put(6, s, 30 + s, 1);
    exp_n = 3;
    for (int k = 0; k < 3; k++) begin exp_pg[k] = 30 + k; exp_ct[k] = 1; end
    walk(0, 6, 1'b0);
    verify("R6 page end", 0, 0, 1, 8);

    // R7 malformed
    put(11, 0, 40, 2); put(11, 1, 0, 5);
    exp_n = 1; exp_pg[0] = 40; exp_ct[0] = 2;
    walk(3, 11, 1'b0);
    verify("R7 zero page nonzero count", 3, 0, 1, 4);

    // R8 self chain loops until the cap
    put(7, 0, 7, 0);
    exp_n = 0;
    walk(1, 7, 1'b0);
    verify("R8 endless chain", 1, 0, 1, 2*MAX_DESC);

    // R8 exactly at the cap
    for (int s = 0; s < 3; s++) begin put(8, s, 50 + s, 1); put(9, s, 60 + s, 1); end
    put(8, 3, 9, 0); put(9, 3, 10, 0); put(10, 0, 70, 1); put(10, 1, 0, 0);
    exp_n = 7;
    for (int k = 0; k < 3; k++) begin
      exp_pg[k] = 50 + k; exp_pg[k+3] = 60 + k; exp_ct[k] = 1; exp_ct[k+3] = 1;
    end
    exp_pg[6] = 70; exp_ct[6] = 1;
    walk(2, 8, 1'b0);
    verify("R8 list at limit", 2, 1, 0, 2*MAX_DESC);

    // R8 one past the cap
    put(10, 1, 71, 1); put(10, 2, 0, 0);
    exp_n = 8; exp_pg[7] = 71; exp_ct[7] = 1;
    walk(2, 8, 1'b0);
    verify("R8 list over limit", 2, 0, 1, 2*MAX_DESC);

    // R9 out of range id, walk and delete
    exp_n = 0;
    walk(MAX_IDS, 1, 1'b0);
    verify("R9 bad id walk", 0, 0, 1, 0);
    walk(MAX_IDS + 7, 0, 1'b0);
    verify("R9 bad id delete", 0, 0, 1, 0);
    chk(del_tot == b_del, "R9 no delete strobe", del_tot - b_del, 0);

    // R10 delete sweep over ids
    for (int id = 0; id < MAX_IDS; id++) begin
      walk(id, 0, 1'b0);
      verify("R10 delete", id, 1, 0, 0);
      chk(del_tot - b_del == 1, "R10 delete strobe", del_tot - b_del, 1);
      chk(last_del_id == id, "R10 delete id", last_del_id, id);
    end

    // R11 writes while busy are ignored
    lat = 3;
    put(1, 0, 80, 2); put(1, 1, 81, 3); put(1, 2, 0, 0);
    exp_n = 2; exp_pg[0] = 80; exp_ct[0] = 2; exp_pg[1] = 81; exp_ct[1] = 3;
    walk(3, 1, 1'b1);
    verify("R11 ignored writes", 3, 1, 0, 6);
    chk(del_tot == b_del, "R11 no delete while busy", del_tot - b_del, 0);
    repeat (30) @(negedge clk);
    chk(rd_tot == b_rd + 6 && dn_tot == b_dn + 1, "R11 no late walk", rd_tot - b_rd, 6);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule